// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds a 32-bit program counter and chooses, once per enabled step, the address the fetch stage uses next. It looks at the opcode field of the instruction that is currently executing. It takes an equality flag that is computed outside the block, and it takes a step enable. From these it either moves on to the following word, jumps within the current 256 MB region, or takes a PC-relative conditional branch. A synchronous reset loads a start address that is set by a parameter.

The PC drives the instruction fetch port directly. Two per-step flags report what the step will do. `branch_taken` marks a conditional branch that will be followed. `redirect` marks any step whose next PC is not the sequential address. Both flags are combinational from the current instruction, so they describe the edge that is about to happen. Register reads, the comparator and instruction memory sit outside the block.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous reset loads `RESET_ADDR` into the PC on the next rising edge, whatever the values of `step_en` and `instr`.
- R2: While `step_en` is low, the PC holds its value, and `branch_taken` and `redirect` are both low.
- R3: On an enabled step, any opcode (`instr[31:26]`) other than 2 and 29 sets the next PC to PC+4. This includes the all-zero no-op word.
- R4: Opcode 2 (jump) sets the next PC to `{(PC+4)[31:28], instr[25:0], 2'b00}`, so bits 1:0 become zero.
- R5: The jump takes its upper four bits from PC+4 and not from PC. A jump executed from the last word of a 256 MB region therefore lands in the next region.
- R6: Opcode 29 (branch-if-equal) with `regs_equal` high sets the next PC to PC+4 plus `instr[15:0]` sign-extended and shifted left by two.
- R7: Opcode 29 with `regs_equal` low sets the next PC to PC+4.
- R8: Branch target arithmetic wraps modulo 2^32, both for negative offsets and for positive offsets.
- R9: `branch_taken` is high only for an enabled, equal branch step. `redirect` is high for an enabled jump step or a taken branch step. For every other opcode, `regs_equal` changes neither flag nor the next PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the PC on this edge |
| instr | input | 32 | Instruction being executed this step |
| regs_equal | input | 1 | Source registers compare equal |
| pc | output | 32 | Current program counter for fetch |
| branch_taken | output | 1 | This step follows a conditional branch |
| redirect | output | 1 | This step leaves the sequential path |

## Verification
The bench builds the block with a start address of 0x40 so that PC values stay in region 0. From there, a branch with the most negative offset wraps below zero, and a jump with an all-ones field reaches the last word of the region. That last-word jump sets up the region-crossing jump of R5. The sweeps cover all 64 opcodes with the equality flag high, a stride through the whole 16-bit offset range with the flag both high and low, and a set of jump fields with walking and boundary bit patterns.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter logic [31:0] RESET_ADDR = 32'h0000_0000,
  parameter int          OPC_JUMP   = 2,
  parameter int          OPC_BRANCH = 29
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        step_en,
  input  logic [31:0] instr,
  input  logic        regs_equal,
  output logic [31:0] pc,
  output logic        branch_taken,
  output logic        redirect
);
  localparam int OPW = 6;

  logic [OPW-1:0] opcode;
  logic           is_jump, is_branch;
  logic [31:0]    seq_pc, jump_pc, br_off, br_pc, next_pc;

  assign opcode    = instr[31:26];
  assign is_jump   = (opcode == OPW'(OPC_JUMP));
  assign is_branch = (opcode == OPW'(OPC_BRANCH));

  assign seq_pc  = pc + 32'd4;
  assign jump_pc = {seq_pc[31:28], instr[25:0], 2'b00};
  assign br_off  = {{14{instr[15]}}, instr[15:0], 2'b00};
  assign br_pc   = seq_pc + br_off;

  assign branch_taken = step_en & is_branch & regs_equal;
  assign redirect     = (step_en & is_jump) | branch_taken;

  always_comb begin
    if (is_jump)           next_pc = jump_pc;
    else if (branch_taken) next_pc = br_pc;
    else                   next_pc = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (rst)          pc <= RESET_ADDR;
    else if (step_en) pc <= next_pc;
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(pc));

  // R3
  sequential_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !redirect) |=> (pc == $past(pc) + 32'd4));

  // R4
  jump_splice_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && is_jump) |=> (pc[27:0] == {$past(instr[25:0]), 2'b00}));

  // R9
  taken_needs_equal_chk: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> (regs_equal && step_en && redirect));

  // R9
  flags_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |-> !(branch_taken || redirect));
endmodule

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
  localparam logic [31:0] START = 32'h0000_0040;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0;
  logic [31:0] instr = 32'd0;
  logic        regs_equal = 1'b0;
  logic [31:0] pc;
  logic        branch_taken, redirect;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [31:0] model_pc;

  always #2 clk = ~clk;

  pc_sequencer #(.RESET_ADDR(START)) u_pc_sequencer (
    .clk(clk), .rst(rst), .step_en(step_en), .instr(instr),
    .regs_equal(regs_equal), .pc(pc), .branch_taken(branch_taken),
    .redirect(redirect));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] ins, input logic eq, input logic en, input string req);
    logic [31:0] seq, nxt;
    logic        exp_tk, exp_rd;
    @(negedge clk);
    instr = ins; regs_equal = eq; step_en = en;
    seq = model_pc + 32'd4;
    exp_tk = 1'b0; exp_rd = 1'b0; nxt = seq;
    if (ins[31:26] == 6'd2) begin
      nxt = (seq & 32'hF000_0000) | ({6'd0, ins[25:0]} * 32'd4);
      exp_rd = 1'b1;
    end else if (ins[31:26] == 6'd29 && eq) begin
      nxt = seq + ($signed({{16{ins[15]}}, ins[15:0]}) * 4);
      exp_tk = 1'b1; exp_rd = 1'b1;
    end
    if (!en) begin nxt = model_pc; exp_tk = 1'b0; exp_rd = 1'b0; end
    #1;
    chk(branch_taken == exp_tk, {req, " taken"}, {31'd0, branch_taken}, {31'd0, exp_tk});
    chk(redirect == exp_rd, {req, " redirect"}, {31'd0, redirect}, {31'd0, exp_rd});
    @(negedge clk);
    model_pc = nxt;
    chk(pc == model_pc, {req, " pc"}, pc, model_pc);
    step_en = 1'b0;
  endtask

  initial begin
    model_pc = START;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk(pc == START, "R1 reset value", pc, START);

    // R2: idle with a jump and a taken branch presented
    step({6'd2, 26'h123_4567}, 1'b1, 1'b0, "R2 idle jump");
    step({6'd29, 10'd0, 16'h0010}, 1'b1, 1'b0, "R2 idle branch");

    // R3 / R9: every opcode except the control ones, equality flag high
    for (int op = 0; op < 64; op++) begin
      if (op != 2 && op != 29)
        step({op[5:0], 26'h2A5_5A5A ^ 26'(op * 977)}, 1'b1, 1'b1, "R3 R9 opcode sweep");
    end
    step(32'd0, 1'b0, 1'b1, "R3 nop");

    // R4: jump fields
    for (int b = 0; b < 26; b++) step({6'd2, 26'd1 << b}, 1'b0, 1'b1, "R4 walking one");
    step({6'd2, 26'h155_5555}, 1'b1, 1'b1, "R4 pattern");
    step({6'd2, 26'h000_0000}, 1'b0, 1'b1, "R4 zero field");

    // R5: last word of region 0, then jump into region 1
    step({6'd2, 26'h3FF_FFFF}, 1'b0, 1'b1, "R5 to last word");
    chk(pc == 32'h0FFF_FFFC, "R5 last word", pc, 32'h0FFF_FFFC);
    step({6'd2, 26'h000_0010}, 1'b0, 1'b1, "R5 cross region");
    chk(pc[31:28] == 4'h1, "R5 upper bits", {28'd0, pc[31:28]}, 32'd1);

    // R1: reset wins over an enabled jump
    @(negedge clk);
    rst = 1'b1; step_en = 1'b1; instr = {6'd2, 26'h0ABCDEF};
    @(negedge clk);
    rst = 1'b0; step_en = 1'b0;
    model_pc = START;
    chk(pc == START, "R1 reset over step", pc, START);

    // R8: most negative offset from a low PC wraps below zero
    step({6'd29, 10'd0, 16'h8000}, 1'b1, 1'b1, "R8 wrap negative");
    chk(pc == 32'hFFFE_0044, "R8 wrap value", pc, 32'hFFFE_0044);
    step({6'd29, 10'd0, 16'h7FFF}, 1'b1, 1'b1, "R8 wrap positive");
    step({6'd29, 10'd0, 16'h7FFF}, 1'b1, 1'b1, "R8 wrap positive again");

    // R6 / R7: stride through the offset range, equal and unequal
    for (int k = 0; k < 65536; k += 97) begin
      step({6'd29, 5'd3, 5'd7, k[15:0]}, 1'b1, 1'b1, "R6 taken sweep");
      step({6'd29, 5'd3, 5'd7, k[15:0]}, 1'b0, 1'b1, "R7 not taken sweep");
    end
    step({6'd29, 10'd0, 16'hFFFF}, 1'b1, 1'b1, "R6 minus one");
    step({6'd29, 10'd0, 16'h0000}, 1'b1, 1'b1, "R6 zero offset");
    step({6'd29, 10'd0, 16'hFFFF}, 1'b0, 1'b1, "R7 minus one");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule